// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers 100 interrupt request lines into 25 groups of four and presents them to a processor through a byte-wide register port. Each line has a detector outside this block. The detector delivers a one-cycle set pulse for that line, and the pulse latches the line's request bit. Groups 0 and 1 are non-maskable. A set in either of them produces a one-cycle non-maskable pulse. Groups 2 to 24 are maskable. Each maskable group has a 4-bit enable mask and a 3-bit priority level, and the block continuously drives the level of the most urgent enabled pending group.

When the processor takes an interrupt, it acknowledges with the level it saw. The block then records the winning group in an accepted-group register that software reads to find the source. If the acknowledged level does not match the presented level, a sticky error flag is raised.

Each group owns an 8-byte window at offset `8*g`: byte 0 holds request and detect, byte 1 holds level and enable, and bytes 2 to 7 are unmapped. The accepted-group register sits at offset 200. All other offsets are unmapped.

Top module: `grp_irq_ctrl`

## Requirements
- R1: A set pulse on `irq_set[n]` sets bit n%4 of the request vector of group n/4 at the next clock edge. For a maskable group, a read of byte 0 returns the request in bits 7:4 and request AND enable in bits 3:0.
- R2: A write to byte 0 of a maskable group sets the request to (request AND d[3:0]) OR (d[7:4] AND d[3:0]). A set pulse in the same cycle still sets its bit.
- R3: A write to byte 1 of a maskable group loads the level from d[6:4] and the enable from d[3:0]. A read of byte 1 returns {0, level, enable}.
- R4: After synchronous reset, every request is 0, every enable is 4'hF and every level is 7. The level output is 7, the accepted-group register reads 0 and the error flag is 0.
- R5: `int_level` equals the smallest level among maskable groups that have (request AND enable) nonzero and a level below 7. It is 7 when no such group exists. It reflects each state change from the clock edge that makes that change.
- R6: For groups 0 and 1, byte 0 reads {4'b0, request}, and writing 1s to bits 3:0 clears those request bits. Byte 1 reads 0, and writes to it are ignored.
- R7: `nmi_pulse` is high for exactly the one cycle after a cycle in which any set pulse arrives on lines 0 to 7.
- R8: An acknowledge whose `ack_level` equals `int_level` latches the winning group. Among equal levels the lowest group number wins. The register at offset 200 then reads that group number shifted left by 2.
- R9: The accepted-group register reads 0 when the latched group no longer has (request AND enable) nonzero. Writes to it are ignored.
- R10: An acknowledge whose `ack_level` differs from `int_level` leaves the accepted-group register unchanged and sets `ack_err`. The flag stays set until reset.
- R11: Reads of unmapped offsets (bytes 2 to 7 of any window, and offsets above 200) return 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_set | input | 100 | Per-line request set pulses |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe for the addressed byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_level | input | 3 | Level the processor accepted |
| int_level | output | 3 | Level of the most urgent maskable request, 7 when idle |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt pulse |
| ack_err | output | 1 | Sticky flag for a level mismatch on acknowledge |

## Verification
The line-to-group mapping is tried with a line that lands in bit 1 of group 3. This separates a correct n/4, n%4 split from one that is shifted by a bit or a group. The arbitration is tried with two groups at the same level, then with the lower group masked, and then with a third group at a more urgent level. These cases tell the lowest-group tie rule apart from a highest-group rule, and a masked request apart from a pending one. Byte-0 writes use mixed keep and set masks, which tells the AND/OR update apart from a plain load. The non-maskable groups, unmapped offsets and writes to the accepted-group register are checked afterwards by reading back the state they could have disturbed.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
    localparam int NUM_GROUPS = 25;
    localparam int NUM_NMI    = 2;
    localparam int LPG        = 4;                 // lines per group
    localparam int LVL_W      = 3;
    localparam int NUM_LINES  = NUM_GROUPS * LPG;
    localparam int GID_W      = $clog2(NUM_GROUPS);
    localparam int WIN_BYTES  = 8;
    localparam int ACC_ADDR   = NUM_GROUPS * WIN_BYTES;
    localparam int ADDR_W     = $clog2(ACC_ADDR + 1);
    localparam logic [LVL_W-1:0] IDLE_LVL = '1;

    typedef struct packed {
        logic [LPG-1:0]   req;
        logic [LPG-1:0]   en;
        logic [LVL_W-1:0] lvl;
    } grp_state_t;

    function automatic logic [7:0] req_byte(grp_state_t s, bit is_nmi);
        if (is_nmi) return {4'b0, s.req};
        return {s.req, s.req & s.en};
    endfunction

    function automatic logic [7:0] cfg_byte(grp_state_t s);
        return {1'b0, s.lvl, s.en};
    endfunction
endpackage

// File: rtl/grp_irq_group.sv
module grp_irq_group
    import grp_irq_pkg::*;
#(
    parameter bit IS_NMI = 1'b0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [LPG-1:0] set_i,
    input  logic           wr_req,
    input  logic           wr_cfg,
    input  logic [7:0]     wdata,
    output grp_state_t     st
);
    logic [LPG-1:0] req_after_wr;

    generate
        if (IS_NMI) begin : g_nmi
            always_comb begin
                req_after_wr = st.req;
                if (wr_req) req_after_wr = st.req & ~wdata[LPG-1:0];
            end
        end else begin : g_mask
            always_comb begin
                req_after_wr = st.req;
                if (wr_req)
                    req_after_wr = (st.req & wdata[LPG-1:0])
                                 | (wdata[7:4] & wdata[LPG-1:0]);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            st.req <= '0;
            st.en  <= '1;
            st.lvl <= IDLE_LVL;
        end else begin
            st.req <= req_after_wr | set_i;
            if (wr_cfg && !IS_NMI) begin
                st.lvl <= wdata[4 +: LVL_W];
                st.en  <= wdata[LPG-1:0];
            end
        end
    end

    // R4: enable comes out of reset fully open
    assert_reset_enable_R4: assert property (@(posedge clk) rst |=> st.en == '1);
    // R2: a set pulse is never lost
    assert_set_kept_R2: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((st.req & $past(set_i)) == $past(set_i)));
    // R3/R6: configuration write lands, or is ignored for NMI groups
    assert_cfg_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_cfg && !IS_NMI) |=> st.en == $past(wdata[LPG-1:0]));
    assert_nmi_cfg_R6: assert property (@(posedge clk) disable iff (rst)
        (IS_NMI && !$isunknown(st.en)) |=> $stable(st.en) && $stable(st.lvl));
endmodule

// File: rtl/grp_irq_arbiter.sv
module grp_irq_arbiter
    import grp_irq_pkg::*;
(
    input  grp_state_t [NUM_GROUPS-1:0] st,
    output logic [GID_W-1:0]            win_grp,
    output logic [LVL_W-1:0]            win_lvl
);
    always_comb begin
        win_grp = '0;
        win_lvl = IDLE_LVL;
        for (int g = NUM_NMI; g < NUM_GROUPS; g++) begin
            if (|(st[g].req & st[g].en) && (st[g].lvl < win_lvl)) begin
                win_grp = GID_W'(g);
                win_lvl = st[g].lvl;
            end
        end
    end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
    import grp_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_set,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic                 ack_valid,
    input  logic [LVL_W-1:0]     ack_level,
    output logic [LVL_W-1:0]     int_level,
    output logic                 nmi_pulse,
    output logic                 ack_err
);
    grp_state_t [NUM_GROUPS-1:0] gst;
    logic [NUM_GROUPS-1:0]       wr_req, wr_cfg;
    logic [GID_W-1:0]            win_grp, acc_grp;
    logic [ADDR_W-4:0]           grp_idx;
    logic [2:0]                  byte_sel;
    logic                        in_win;
    logic                        nmi_q, err_q;
    logic [NUM_NMI-1:0]          nmi_hit;

    assign grp_idx  = bus_addr[ADDR_W-1:3];
    assign byte_sel = bus_addr[2:0];
    assign in_win   = int'(bus_addr) < ACC_ADDR;

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
            assign wr_req[g] = bus_wr && in_win && (int'(grp_idx) == g) && (byte_sel == 3'd0);
            assign wr_cfg[g] = bus_wr && in_win && (int'(grp_idx) == g) && (byte_sel == 3'd1);
            grp_irq_group #(.IS_NMI(g < NUM_NMI)) u_grp (
                .clk    (clk),
                .rst    (rst),
                .set_i  (irq_set[g*LPG +: LPG]),
                .wr_req (wr_req[g]),
                .wr_cfg (wr_cfg[g]),
                .wdata  (bus_wdata),
                .st     (gst[g])
            );
        end
        for (g = 0; g < NUM_NMI; g++) begin : g_nmi_hit
            assign nmi_hit[g] = |(irq_set[g*LPG +: LPG] & gst[g].en);
        end
    endgenerate

    grp_irq_arbiter u_arb (
        .st      (gst),
        .win_grp (win_grp),
        .win_lvl (int_level)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q   <= 1'b0;
            err_q   <= 1'b0;
            acc_grp <= '0;
        end else begin
            nmi_q <= |nmi_hit;
            if (ack_valid) begin
                if (ack_level == int_level) acc_grp <= win_grp;
                else                        err_q   <= 1'b1;
            end
        end
    end

    assign nmi_pulse = nmi_q;
    assign ack_err   = err_q;

    always_comb begin
        bus_rdata = '0;
        if (in_win) begin
            if (byte_sel == 3'd0)
                bus_rdata = req_byte(gst[grp_idx], int'(grp_idx) < NUM_NMI);
            else if (byte_sel == 3'd1 && int'(grp_idx) >= NUM_NMI)
                bus_rdata = cfg_byte(gst[grp_idx]);
        end else if (int'(bus_addr) == ACC_ADDR) begin
            if (int'(acc_grp) >= NUM_NMI && |(gst[acc_grp].req & gst[acc_grp].en))
                bus_rdata = 8'({acc_grp, 2'b00});
        end
    end

    // R5: a non-idle level always belongs to a pending enabled group
    assert_level_source_R5: assert property (@(posedge clk) disable iff (rst)
        (int_level != IDLE_LVL) |-> (|(gst[win_grp].req & gst[win_grp].en)
                                     && gst[win_grp].lvl == int_level));
    // R7: a set on an NMI line yields a pulse one cycle later
    assert_nmi_follow_R7: assert property (@(posedge clk) disable iff (rst)
        (|irq_set[NUM_NMI*LPG-1:0]) |=> nmi_pulse);
    // R10: error flag is sticky
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        ack_err |=> ack_err);
    // R8: a matching acknowledge latches the winner
    assert_ack_latch_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_level == int_level) |=> acc_grp == $past(win_grp));
    // R10: a mismatching acknowledge leaves the accepted group alone
    assert_ack_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_level != int_level) |=> $stable(acc_grp) && ack_err);
endmodule

// File: tb/grp_irq_ctrl_test.sv
module grp_irq_ctrl_test;
    import grp_irq_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NUM_LINES-1:0] irq_set = '0;
    logic [ADDR_W-1:0]    bus_addr = '0;
    logic                 bus_wr = 1'b0;
    logic [7:0]           bus_wdata = '0;
    logic [7:0]           bus_rdata;
    logic                 ack_valid = 1'b0;
    logic [LVL_W-1:0]     ack_level = '0;
    logic [LVL_W-1:0]     int_level;
    logic                 nmi_pulse;
    logic                 ack_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    grp_irq_ctrl uut (
        .clk(clk), .rst(rst), .irq_set(irq_set), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_valid(ack_valid), .ack_level(ack_level), .int_level(int_level),
        .nmi_pulse(nmi_pulse), .ack_err(ack_err)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(string tag, int a, int exp);
        @(negedge clk);
        bus_addr = ADDR_W'(a);
        #1 check(tag, int'(bus_rdata), exp);
    endtask

    task automatic pulse(int line);
        @(negedge clk);
        irq_set[line] = 1'b1;
        @(negedge clk);
        irq_set[line] = 1'b0;
    endtask

    task automatic ack(int lvl);
        @(negedge clk);
        ack_valid = 1'b1; ack_level = LVL_W'(lvl);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic t_reset;
        rd_check("R4 cfg byte g2", 2*8+1, 8'h7F);
        rd_check("R4 req byte g2", 2*8, 0);
        rd_check("R4 accepted reg", ACC_ADDR, 0);
        check("R4 int_level", int'(int_level), 7);
        check("R4 ack_err", int'(ack_err), 0);
        check("R4 nmi_pulse", int'(nmi_pulse), 0);
    endtask

    task automatic t_mapping;
        pulse(13);                              // group 3, bit 1
        rd_check("R1 line 13 -> g3 bit1", 3*8, 8'h22);
        check("R5 level 7 request stays idle", int'(int_level), 7);
        wr(3*8+1, 8'h2F);
        rd_check("R3 cfg readback", 3*8+1, 8'h2F);
        check("R5 level after cfg", int'(int_level), 2);
    endtask

    task automatic t_priority;
        pulse(40);                              // group 10 bit 0
        wr(10*8+1, 8'h1F);
        check("R5 more urgent group wins", int'(int_level), 1);
        pulse(20);                              // group 5 bit 0
        wr(5*8+1, 8'h1F);
        ack(1);
        rd_check("R8 tie to lowest group", ACC_ADDR, 5*4);
        wr(5*8+1, 8'h10);                       // mask group 5
        rd_check("R1 masked detect bits", 5*8, 8'h10);
        check("R5 masked group ignored", int'(int_level), 1);
        rd_check("R9 accepted reads 0 after mask", ACC_ADDR, 0);
    endtask

    task automatic t_clear_ack;
        wr(10*8, 8'h0E);                        // keep bits 3:1, drop bit 0
        rd_check("R2 clear by keep mask", 10*8, 8'h00);
        wr(3*8, 8'h44);                         // drop bit1, set bit2
        rd_check("R2 keep and set", 3*8, 8'h44);
        check("R5 level falls back to g3", int'(int_level), 2);
        ack(2);
        rd_check("R8 accepted g3", ACC_ADDR, 3*4);
        ack(5);
        check("R10 mismatch flags error", int'(ack_err), 1);
        rd_check("R10 accepted unchanged", ACC_ADDR, 3*4);
        ack(2);
        check("R10 error sticky", int'(ack_err), 1);
    endtask

    task automatic t_nmi;
        @(negedge clk);
        irq_set[5] = 1'b1;                      // group 1 bit 1
        @(negedge clk);
        irq_set[5] = 1'b0;
        #1 check("R7 nmi pulse high", int'(nmi_pulse), 1);
        @(negedge clk);
        #1 check("R7 nmi pulse one cycle", int'(nmi_pulse), 0);
        rd_check("R6 nmi request read", 1*8, 8'h02);
        check("R5 nmi leaves level", int'(int_level), 2);
        wr(1*8+1, 8'h00);
        rd_check("R6 nmi cfg reads 0", 1*8+1, 0);
        wr(1*8, 8'h02);
        rd_check("R6 write one clears", 1*8, 0);
    endtask

    task automatic t_unmapped;
        wr(3*8+3, 8'hFF);
        rd_check("R11 unmapped byte reads 0", 3*8+3, 0);
        rd_check("R11 g3 req untouched", 3*8, 8'h44);
        rd_check("R11 g3 cfg untouched", 3*8+1, 8'h2F);
        wr(ACC_ADDR, 8'hFF);
        rd_check("R9 accepted write ignored", ACC_ADDR, 3*4);
        wr(255, 8'hFF);
        rd_check("R11 high offset reads 0", 255, 0);
        check("R11 level unchanged", int'(int_level), 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_mapping;
        t_priority;
        t_clear_ack;
        t_nmi;
        t_unmapped;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule